// File: doc/BRIEF.md
# Serial EEPROM Byte Access and Burst Loader

This block sits between a host register bus and a byte-wide serial EEPROM. Software uses it in two ways. For single-byte work it fills an address register and a data register, then sets a read or write request bit in the control register. The hardware clears that bit when the access is finished, and a read result is valid once the bit reads back as 0.

For bulk configuration, software sets the start bit of a separate start register. The controller then walks the EEPROM as a list of records. Each record is three bytes: an address high byte, an address low byte, and a data byte. Each data byte is written to an internal memory port. The controller stops at a record whose address is 0xFFFF.

The EEPROM is reached through a request/acknowledge byte port. The request stays up, with its write flag, address and write data held steady, until the EEPROM acknowledges it. The EEPROM may stall for any number of cycles, and that is its only form of back-pressure. A programmable watchdog abandons an access that is never acknowledged. The memory write port has no back-pressure: a write is one cycle of `mem_we`.

Top module: `eel_top`

## Requirements
- R1: After reset, the control register (offset 0) and the start register (offset 3) both read back as 0.
- R2: Writing control bit 1 (the read request) performs one EEPROM read at the address register (offset 1). The byte is loaded into the data register (offset 2), and bit 1 clears on the edge where the acknowledge is sampled.
- R3: Writing control bit 0 (the write request) performs one EEPROM write of data register bits [7:0] to the address register. Bit 0 clears on the edge where the acknowledge is sampled.
- R4: Control bit 2 reads 1 while any access or burst is in progress. While that bit is 1, a request written to the control or start register is ignored.
- R5: Writing start bit 0 begins a burst. Each record is read as the high address byte, then the low address byte, then one data byte. A record address of 0xFFFF ends the burst without reading a data byte, and start bit 0 then clears.
- R6: Every burst data byte is written once on the memory port. The 24-bit memory address is {base register [8:0] (offset 4), record address [14:0]}, so record address bit 15 is discarded.
- R7: A burst started with no earlier EEPROM access since reset begins at EEPROM address 0. Otherwise it begins one past the address of the last EEPROM access.
- R8: While `ee_req` is high and `ee_ack` is low, `ee_req`, `ee_we`, `ee_addr` and `ee_wdata` hold their values into the next cycle, unless the watchdog expires.
- R9: If an access sees no acknowledge for as many request cycles as the limit register (offset 5) holds, the request is dropped and the pending request bit clears. The sticky flag, control bit 3, is set. A limit of 0 disables the watchdog.
- R10: Writing 1 to control bit 3 clears the timeout flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word offset |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| ee_req | output | 1 | EEPROM access request, held until acknowledged |
| ee_we | output | 1 | 1 = write access, 0 = read access |
| ee_addr | output | 16 | EEPROM byte address |
| ee_wdata | output | 8 | Byte to write |
| ee_ack | input | 1 | EEPROM acknowledge, one cycle |
| ee_rdata | input | 8 | Read byte, valid with `ee_ack` |
| mem_we | output | 1 | Burst memory write strobe |
| mem_addr | output | 24 | Burst memory byte address |
| mem_wdata | output | 8 | Burst memory write byte |

## Verification
A request is accepted on the edge that samples the register write, and `ee_req` is high after that same edge. Request bits, busy, and the data register change on the edge that samples `ee_ack`. A memory write appears in the cycle after the data byte's acknowledge. With a limit of N and no acknowledge, the access is abandoned on the Nth edge after launch.

The bench drives and samples at falling edges. It polls the busy bit with a bounded count instead of assuming a fixed latency. For the timeout, it checks that the poll count falls in a narrow window around N.

// File: rtl/eel_pkg.sv
package eel_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ONE,
    ST_HI,
    ST_LO,
    ST_DAT
  } eel_state_t;

  localparam logic [2:0] REG_CTRL  = 3'd0;
  localparam logic [2:0] REG_ADDR  = 3'd1;
  localparam logic [2:0] REG_DATA  = 3'd2;
  localparam logic [2:0] REG_START = 3'd3;
  localparam logic [2:0] REG_BASE  = 3'd4;
  localparam logic [2:0] REG_LIMIT = 3'd5;

  localparam int CB_WR   = 0;
  localparam int CB_RD   = 1;
  localparam int CB_BUSY = 2;
  localparam int CB_TMO  = 3;
endpackage

// File: rtl/eel_port.sv
module eel_port #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          launch,
  input  logic          launch_we,
  input  logic [AW-1:0] launch_addr,
  input  logic [7:0]    launch_wdata,
  input  logic [CW-1:0] limit,
  input  logic          ee_ack,
  input  logic [7:0]    ee_rdata,
  output logic          ee_req,
  output logic          ee_we,
  output logic [AW-1:0] ee_addr,
  output logic [7:0]    ee_wdata,
  output logic          done,
  output logic          tmo,
  output logic [7:0]    rdata
);
  logic [CW-1:0] cnt;

  assign done  = ee_req & ee_ack;
  assign tmo   = ee_req & ~ee_ack & (limit != '0) & (cnt == limit - CW'(1));
  assign rdata = ee_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ee_req   <= 1'b0;
      ee_we    <= 1'b0;
      ee_addr  <= '0;
      ee_wdata <= '0;
      cnt      <= '0;
    end else if (launch) begin
      ee_req   <= 1'b1;
      ee_we    <= launch_we;
      ee_addr  <= launch_addr;
      ee_wdata <= launch_wdata;
      cnt      <= '0;
    end else if (done || tmo) begin
      ee_req <= 1'b0;
    end else if (ee_req) begin
      cnt <= cnt + CW'(1);
    end
  end
endmodule

// File: rtl/eel_ctrl.sv
module eel_ctrl
  import eel_pkg::*;
#(
  parameter int AW = 16,
  parameter int BW = 9,
  parameter int MW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go_rd,
  input  logic          go_wr,
  input  logic          go_burst,
  input  logic          clr_flag,
  input  logic [AW-1:0] addr_reg,
  input  logic [7:0]    data_reg,
  input  logic [BW-1:0] base,
  input  logic          done,
  input  logic          tmo,
  input  logic [7:0]    rdata,
  output logic          launch,
  output logic          launch_we,
  output logic [AW-1:0] launch_addr,
  output logic [7:0]    launch_wdata,
  output logic          rd_pend,
  output logic          wr_pend,
  output logic          burst_pend,
  output logic          busy,
  output logic          tmo_flag,
  output logic          load_data,
  output logic          mem_we,
  output logic [MW-1:0] mem_addr,
  output logic [7:0]    mem_wdata
);
  localparam int LOW = MW - BW;

  eel_state_t     state;
  logic [AW-1:0]  cursor;
  logic [7:0]     hi_q;
  logic [LOW-1:0] rec_q;
  logic           op_rd;
  logic [AW-1:0]  rec_full;
  logic           rec_end;

  assign rec_full   = {hi_q, rdata};
  assign rec_end    = (rec_full == '1);
  assign busy       = (state != ST_IDLE);
  assign rd_pend    = (state == ST_ONE) & op_rd;
  assign wr_pend    = (state == ST_ONE) & ~op_rd;
  assign burst_pend = (state == ST_HI) | (state == ST_LO) | (state == ST_DAT);
  assign load_data  = rd_pend & done;

  always_comb begin
    launch       = 1'b0;
    launch_we    = 1'b0;
    launch_addr  = cursor + AW'(1);
    launch_wdata = data_reg;
    case (state)
      ST_IDLE: begin
        if (go_rd || go_wr) begin
          launch      = 1'b1;
          launch_we   = ~go_rd;
          launch_addr = addr_reg;
        end else if (go_burst) begin
          launch      = 1'b1;
          launch_addr = cursor;
        end
      end
      ST_HI, ST_DAT: launch = done;
      ST_LO:         launch = done & ~rec_end;
      default:       launch = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cursor    <= '0;
      hi_q      <= '0;
      rec_q     <= '0;
      op_rd     <= 1'b0;
      tmo_flag  <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      mem_we <= 1'b0;
      if (tmo) tmo_flag <= 1'b1;
      else if (clr_flag) tmo_flag <= 1'b0;
      if (state != ST_IDLE && (done || tmo)) cursor <= cursor + AW'(1);
      if (tmo) begin
        state <= ST_IDLE;
      end else begin
        case (state)
          ST_IDLE: begin
            if (go_rd || go_wr) begin
              state  <= ST_ONE;
              op_rd  <= go_rd;
              cursor <= addr_reg;
            end else if (go_burst) begin
              state <= ST_HI;
            end
          end
          ST_ONE: if (done) state <= ST_IDLE;
          ST_HI: if (done) begin
            hi_q  <= rdata;
            state <= ST_LO;
          end
          ST_LO: if (done) begin
            rec_q <= rec_full[LOW-1:0];
            state <= rec_end ? ST_IDLE : ST_DAT;
          end
          ST_DAT: if (done) begin
            mem_we    <= 1'b1;
            mem_addr  <= {base, rec_q};
            mem_wdata <= rdata;
            state     <= ST_HI;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/eel_top.sv
module eel_top
  import eel_pkg::*;
#(
  parameter int AW        = 16,
  parameter int BW        = 9,
  parameter int MW        = 24,
  parameter int DW        = 16,
  parameter int CW        = 16,
  parameter int DEF_LIMIT = 1000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [2:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          ee_req,
  output logic          ee_we,
  output logic [AW-1:0] ee_addr,
  output logic [7:0]    ee_wdata,
  input  logic          ee_ack,
  input  logic [7:0]    ee_rdata,
  output logic          mem_we,
  output logic [MW-1:0] mem_addr,
  output logic [7:0]    mem_wdata
);
  logic [AW-1:0] addr_q;
  logic [7:0]    data_q;
  logic [BW-1:0] base_q;
  logic [CW-1:0] limit_q;

  logic          launch, launch_we, port_done, port_tmo;
  logic [AW-1:0] launch_addr;
  logic [7:0]    launch_wdata, port_rdata;
  logic          rd_pend, wr_pend, burst_pend, busy, tmo_flag, load_data;
  logic          ctrl_wr, go_rd, go_wr, go_burst, clr_flag;

  assign ctrl_wr  = reg_wr && (reg_addr == REG_CTRL);
  assign go_rd    = ctrl_wr && !busy && reg_wdata[CB_RD];
  assign go_wr    = ctrl_wr && !busy && !reg_wdata[CB_RD] && reg_wdata[CB_WR];
  assign go_burst = reg_wr && (reg_addr == REG_START) && !busy && reg_wdata[0];
  assign clr_flag = ctrl_wr && reg_wdata[CB_TMO];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      data_q  <= '0;
      base_q  <= '0;
      limit_q <= CW'(DEF_LIMIT);
    end else begin
      if (reg_wr) begin
        case (reg_addr)
          REG_ADDR:  addr_q  <= reg_wdata[AW-1:0];
          REG_DATA:  data_q  <= reg_wdata[7:0];
          REG_BASE:  base_q  <= reg_wdata[BW-1:0];
          REG_LIMIT: limit_q <= reg_wdata[CW-1:0];
          default: ;
        endcase
      end
      if (load_data) data_q <= port_rdata;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      REG_CTRL: begin
        reg_rdata[CB_WR]   = wr_pend;
        reg_rdata[CB_RD]   = rd_pend;
        reg_rdata[CB_BUSY] = busy;
        reg_rdata[CB_TMO]  = tmo_flag;
      end
      REG_ADDR:  reg_rdata[AW-1:0] = addr_q;
      REG_DATA:  reg_rdata[7:0]    = data_q;
      REG_START: reg_rdata[0]      = burst_pend;
      REG_BASE:  reg_rdata[BW-1:0] = base_q;
      REG_LIMIT: reg_rdata[CW-1:0] = limit_q;
      default:   reg_rdata = '0;
    endcase
  end

  eel_port #(.AW(AW), .CW(CW)) u_port (
    .clk(clk), .rst_n(rst_n),
    .launch(launch), .launch_we(launch_we), .launch_addr(launch_addr),
    .launch_wdata(launch_wdata), .limit(limit_q),
    .ee_ack(ee_ack), .ee_rdata(ee_rdata),
    .ee_req(ee_req), .ee_we(ee_we), .ee_addr(ee_addr), .ee_wdata(ee_wdata),
    .done(port_done), .tmo(port_tmo), .rdata(port_rdata)
  );

  eel_ctrl #(.AW(AW), .BW(BW), .MW(MW)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .go_rd(go_rd), .go_wr(go_wr), .go_burst(go_burst), .clr_flag(clr_flag),
    .addr_reg(addr_q), .data_reg(data_q), .base(base_q),
    .done(port_done), .tmo(port_tmo), .rdata(port_rdata),
    .launch(launch), .launch_we(launch_we), .launch_addr(launch_addr),
    .launch_wdata(launch_wdata),
    .rd_pend(rd_pend), .wr_pend(wr_pend), .burst_pend(burst_pend),
    .busy(busy), .tmo_flag(tmo_flag), .load_data(load_data),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );
endmodule

// File: rtl/eel_sva.sv
module eel_sva #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr,
  input logic [2:0]    reg_addr,
  input logic          ee_req,
  input logic          ee_ack,
  input logic          ee_we,
  input logic [AW-1:0] ee_addr,
  input logic [7:0]    ee_wdata,
  input logic          mem_we,
  input logic          rd_pend,
  input logic          wr_pend,
  input logic          burst_pend,
  input logic          busy,
  input logic          port_done,
  input logic          port_tmo,
  input logic          tmo_flag
);
  logic ctrl_wr;
  assign ctrl_wr = reg_wr && (reg_addr == 3'd0);

  // R8: request and its payload stay put until acknowledged
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ee_req && !ee_ack && !port_tmo) |=>
      (ee_req && $stable(ee_we) && $stable(ee_addr) && $stable(ee_wdata)));

  // R4: at most one kind of work pending
  assert_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_pend, wr_pend, burst_pend}));

  // R4: control writes during busy leave the pending bits alone
  assert_ignore_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ctrl_wr && !port_done && !port_tmo) |=> $stable({rd_pend, wr_pend}));

  // R6: memory writes only come from a burst
  assert_memwe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> burst_pend);

  // R9: an abandoned access raises the flag and frees the block
  assert_tmo_R9: assert property (@(posedge clk) disable iff (!rst_n)
    port_tmo |=> (tmo_flag && !busy));

  // R5: a finished burst leaves no request outstanding
  assert_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(burst_pend) |-> !ee_req);
endmodule

bind eel_top eel_sva #(.AW(AW)) u_sva (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .ee_req(ee_req), .ee_ack(ee_ack), .ee_we(ee_we), .ee_addr(ee_addr),
  .ee_wdata(ee_wdata), .mem_we(mem_we), .rd_pend(rd_pend), .wr_pend(wr_pend),
  .burst_pend(burst_pend), .busy(busy), .port_done(port_done),
  .port_tmo(port_tmo), .tmo_flag(tmo_flag)
);

// File: tb/eel_top_tb.sv
`timescale 1ns/100ps
module eel_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [15:0] reg_wdata = 16'd0;
  logic [15:0] reg_rdata;
  logic        ee_req, ee_we;
  logic [15:0] ee_addr;
  logic [7:0]  ee_wdata;
  logic        ee_ack = 1'b0;
  logic [7:0]  ee_rdata = 8'd0;
  logic        mem_we;
  logic [23:0] mem_addr;
  logic [7:0]  mem_wdata;

  int total = 0;
  int bad = 0;
  int ack_delay = 0;
  int wait_cnt = 0;
  bit no_ack = 0;
  int ee_writes = 0;
  bit finished = 0;
  logic [7:0]  ee_mem [0:255];
  logic [23:0] cap_addr [0:15];
  logic [7:0]  cap_data [0:15];
  int cap_n = 0;

  always #2.5 clk = ~clk;

  eel_top u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ee_req(ee_req), .ee_we(ee_we), .ee_addr(ee_addr), .ee_wdata(ee_wdata),
    .ee_ack(ee_ack), .ee_rdata(ee_rdata),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  // behavioural EEPROM
  initial begin
    forever begin
      @(negedge clk);
      if (ee_ack) begin
        ee_ack = 1'b0;
        wait_cnt = 0;
      end else if (ee_req && !no_ack) begin
        if (wait_cnt >= ack_delay) begin
          ee_ack = 1'b1;
          if (ee_we) begin
            ee_mem[ee_addr[7:0]] = ee_wdata;
            ee_writes++;
          end else begin
            ee_rdata = ee_mem[ee_addr[7:0]];
          end
        end else begin
          wait_cnt++;
        end
      end
    end
  end

  // memory port monitor
  initial begin
    forever begin
      @(negedge clk);
      if (mem_we && cap_n < 16) begin
        cap_addr[cap_n] = mem_addr;
        cap_data[cap_n] = mem_wdata;
        cap_n++;
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1;
    reg_addr = a;
    reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [15:0] d);
    reg_addr = a;
    #0.1;
    d = reg_rdata;
  endtask

  task automatic wait_idle(output int polls);
    logic [15:0] v;
    polls = 0;
    for (int i = 0; i < 500; i++) begin
      @(negedge clk);
      polls++;
      reg_read(3'd0, v);
      if (!v[2]) break;
    end
  endtask

  task automatic t_reset;
    logic [15:0] v;
    reg_read(3'd0, v);
    check("R1 ctrl after reset", v, 0);
    reg_read(3'd3, v);
    check("R1 start after reset", v, 0);
  endtask

  task automatic t_burst_from_zero;
    logic [15:0] v;
    int p;
    reg_write(3'd4, 16'h01A5);
    reg_write(3'd3, 16'h0001);
    reg_read(3'd3, v);
    check("R5 start bit during burst", v[0], 1);
    wait_idle(p);
    reg_read(3'd3, v);
    check("R5 start bit cleared", v[0], 0);
    check("R6 write count", cap_n, 2);
    check("R6 R7 first address", cap_addr[0], (24'h1A5 << 15) | 24'h0010);
    check("R6 first byte", cap_data[0], 8'hAA);
    check("R6 top record bit dropped", cap_addr[1], (24'h1A5 << 15) | 24'h0011);
    check("R6 second byte", cap_data[1], 8'hBB);
  endtask

  task automatic t_single_read;
    logic [15:0] v;
    int p;
    reg_write(3'd1, 16'h0040);
    reg_write(3'd0, 16'h0002);
    wait_idle(p);
    reg_read(3'd0, v);
    check("R2 read bit cleared", v[1], 0);
    reg_read(3'd2, v);
    check("R2 read data", v, 16'h0033);
  endtask

  task automatic t_burst_resume;
    int p;
    cap_n = 0;
    reg_write(3'd3, 16'h0001);
    wait_idle(p);
    check("R7 resume write count", cap_n, 1);
    check("R7 resume address", cap_addr[0], (24'h1A5 << 15) | 24'h0123);
    check("R7 resume byte", cap_data[0], 8'h5A);
  endtask

  task automatic t_single_write;
    logic [15:0] v;
    int p;
    reg_write(3'd1, 16'h0030);
    reg_write(3'd2, 16'h005C);
    reg_write(3'd0, 16'h0001);
    wait_idle(p);
    reg_read(3'd0, v);
    check("R3 write bit cleared", v[0], 0);
    check("R3 eeprom byte written", ee_mem[8'h30], 8'h5C);
  endtask

  task automatic t_busy_ignore;
    logic [15:0] v;
    int p, w0;
    ack_delay = 10;
    reg_write(3'd1, 16'h0050);
    reg_write(3'd0, 16'h0002);
    reg_read(3'd0, v);
    check("R4 busy and read pending", v[2:0], 3'b110);
    w0 = ee_writes;
    reg_write(3'd0, 16'h0001);
    reg_read(3'd0, v);
    check("R4 write request ignored in ctrl", v[0], 0);
    wait_idle(p);
    check("R4 no eeprom write issued", ee_writes, w0);
    reg_read(3'd2, v);
    check("R4 R8 slow read data", v, 16'h0077);
    ack_delay = 0;
  endtask

  task automatic t_timeout;
    logic [15:0] v;
    int p;
    reg_write(3'd5, 16'd8);
    no_ack = 1;
    reg_write(3'd0, 16'h0002);
    wait_idle(p);
    check("R9 abandon time in window", (p >= 6 && p <= 10), 1);
    reg_read(3'd0, v);
    check("R9 flag set, request cleared", v[3:0], 4'b1000);
    check("R9 request dropped", ee_req, 0);
    reg_write(3'd0, 16'h0008);
    reg_read(3'd0, v);
    check("R10 flag cleared", v[3:0], 4'b0000);
    no_ack = 0;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) ee_mem[i] = 8'h00;
    ee_mem[0] = 8'h00; ee_mem[1] = 8'h10; ee_mem[2] = 8'hAA;
    ee_mem[3] = 8'h80; ee_mem[4] = 8'h11; ee_mem[5] = 8'hBB;
    ee_mem[6] = 8'hFF; ee_mem[7] = 8'hFF;
    ee_mem[8'h40] = 8'h33;
    ee_mem[8'h41] = 8'h01; ee_mem[8'h42] = 8'h23; ee_mem[8'h43] = 8'h5A;
    ee_mem[8'h44] = 8'hFF; ee_mem[8'h45] = 8'hFF;
    ee_mem[8'h50] = 8'h77;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_burst_from_zero();
    t_single_read();
    t_burst_resume();
    t_single_write();
    t_busy_ignore();
    t_timeout();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule